// File: doc/BRIEF.md
# Double-Buffered I2C Write Command Register

This block is an I2C target that accepts only write transfers and keeps a 16-bit command word for the logic around it. A transfer carries a 7-bit address with a write direction bit, followed by exactly two data bytes with the most significant byte first. Each accepted byte is copied into a staging (holding) register at the moment its acknowledge is driven. The visible command word takes the staged value only when a later Stop condition is seen on the bus.

The design filters out damaged frames. A Stop that arrives part-way through a frame commits nothing. A complete, staged pair survives any number of Repeat-Starts that address other targets, and the next Stop commits it. When a Repeat-Start re-addresses this target and its first new byte is acknowledged, Stops are ignored until the second new byte has also been acknowledged. Each commit raises a single-cycle strobe. SCL and SDA arrive asynchronously and are synchronised inside the block. The acknowledge is an open-drain pull-low enable.

Top module: `i2c_cmd_reg`

## Requirements
- R1: After reset, `cmd_o` reads 16'hFF00, and `sda_oe_o` and `cmd_upd_o` are low.
- R2: A frame whose first byte holds the device address in bits 7:1 and a 0 in bit 0 (write) receives an acknowledge on the 9th SCL clock.
- R3: A frame with a different address, or with bit 0 equal to 1 (read), receives no acknowledge. Its data bytes are not acknowledged, and it leaves both the command word and any staged data unchanged.
- R4: After an acknowledged address, the first two data bytes are acknowledged and staged: the first as bits 15:8, the second as bits 7:0. A third byte is not acknowledged.
- R5: `cmd_o` changes only when a Stop follows a frame in which both data bytes were acknowledged. It does not change when the second byte is acknowledged.
- R6: A Stop that arrives after the address but before the second data byte is acknowledged leaves `cmd_o` unchanged. The frame is dropped.
- R7: Staged complete data is kept across any number of Repeat-Starts to other addresses, and the next Stop commits it.
- R8: When a Repeat-Start re-addresses the block, acknowledging the first new byte cancels the staged pair. No Stop commits anything until the second new byte is acknowledged.
- R9: `cmd_upd_o` is high for exactly one clock cycle for each update of `cmd_o`, and it stays low otherwise.
- R10: The acknowledge drive starts after the falling edge of the 8th SCL clock of a byte and is released after the falling edge of the 9th.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | Pull SDA low when high (acknowledge) |
| cmd_o | output | 16 | Committed command word |
| cmd_upd_o | output | 1 | One-cycle strobe on each command update |

## Verification
Every bus edge reaches the decision logic three clocks later: two for synchronisation and one for the registered action. The bench therefore holds each bus phase for six clocks and samples only at the end of a phase. The acknowledge is read in the middle of the 9th SCL high time. Its release is checked six clocks after the 9th falling edge, and its absence is checked during the high time of the 8th SCL clock. The command word and the count of commit strobes are compared six clocks after each Stop rising edge. After each acknowledge the command word is compared again, to confirm that nothing commits early.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int unsigned CMD_W      = 16;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned CMD_BYTES  = CMD_W / BYTE_W;
  localparam logic [CMD_W-1:0] CMD_RST = 16'hFF00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK,
    ST_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2c_cmd_sync.sv
module i2c_cmd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_p  <= scl_sr[STAGES-1];
      sda_p  <= sda_sr[STAGES-1];
    end
  end

  logic scl_s;
  assign scl_s      = scl_sr[STAGES-1];
  assign sda_o      = sda_sr[STAGES-1];
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  // SDA edges while SCL stays high
  assign start_o    = scl_s & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_cmd_rx.sv
module i2c_cmd_rx
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_oe_o,
  output logic              byte_ack_o,
  output logic              byte_sel_o,
  output logic [BYTE_W-1:0] byte_data_o
);
  localparam logic [3:0] BIT_LAST = 4'(BYTE_W);
  localparam logic [1:0] N_BYTES  = 2'(CMD_BYTES);

  rx_state_e         state_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic [1:0]        byte_idx_q;
  logic              ack_data_q;
  logic              byte_done;

  assign byte_done   = scl_fall_i && (bit_cnt_q == BIT_LAST);
  assign byte_ack_o  = (state_q == ST_DATA) && byte_done && (byte_idx_q < N_BYTES);
  assign byte_sel_o  = byte_idx_q[0];
  assign byte_data_o = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      byte_idx_q <= '0;
      ack_data_q <= 1'b0;
      sda_oe_o   <= 1'b0;
    end else if (start_i) begin
      state_q    <= ST_ADDR;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      sda_oe_o   <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise_i && bit_cnt_q < BIT_LAST) begin
            shift_q   <= {shift_q[BYTE_W-2:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end
          if (byte_done) begin
            if (state_q == ST_ADDR) begin
              if (shift_q == {DEV_ADDR, 1'b0}) begin
                state_q    <= ST_ACK;
                sda_oe_o   <= 1'b1;
                ack_data_q <= 1'b0;
              end else begin
                state_q <= ST_SKIP;
              end
            end else if (byte_idx_q < N_BYTES) begin
              state_q    <= ST_ACK;
              sda_oe_o   <= 1'b1;
              ack_data_q <= 1'b1;
              byte_idx_q <= byte_idx_q + 2'd1;
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            sda_oe_o  <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= (ack_data_q && byte_idx_q == N_BYTES) ? ST_SKIP : ST_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  AST_ACK_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall_i)); // R10
  AST_RELEASE_ON_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o); // R6
  AST_RELEASE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> $past(scl_fall_i || start_i || stop_i)); // R10
endmodule

// File: rtl/i2c_cmd_hold.sv
module i2c_cmd_hold
  import i2c_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_ack_i,
  input  logic              byte_sel_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              stop_i,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              cmd_upd_o
);
  logic [CMD_W-1:0] hold_q;
  logic             pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q    <= CMD_RST;
      pend_q    <= 1'b0;
      cmd_o     <= CMD_RST;
      cmd_upd_o <= 1'b0;
    end else begin
      cmd_upd_o <= 1'b0;
      if (byte_ack_i) begin
        if (byte_sel_i) begin
          hold_q[BYTE_W-1:0] <= byte_data_i;
          pend_q             <= 1'b1;
        end else begin
          // new frame under way: old pair no longer commits
          hold_q[CMD_W-1:BYTE_W] <= byte_data_i;
          pend_q                 <= 1'b0;
        end
      end else if (stop_i && pend_q) begin
        cmd_o     <= hold_q;
        cmd_upd_o <= 1'b1;
        pend_q    <= 1'b0;
      end
    end
  end

  AST_CMD_ONLY_ON_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != $past(cmd_o)) |-> cmd_upd_o); // R5
  AST_UPD_NEEDS_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_upd_o |-> $past(stop_i)); // R5
  AST_UPD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_upd_o |=> !cmd_upd_o); // R9
  AST_PEND_FROM_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(byte_ack_i && byte_sel_i)); // R4
endmodule

// File: rtl/i2c_cmd_reg.sv
module i2c_cmd_reg
  import i2c_cmd_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h4B,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             cmd_upd_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              byte_ack, byte_sel;
  logic [BYTE_W-1:0] byte_data;

  i2c_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_cmd_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_i       (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .sda_oe_o    (sda_oe_o),
    .byte_ack_o  (byte_ack),
    .byte_sel_o  (byte_sel),
    .byte_data_o (byte_data)
  );

  i2c_cmd_hold u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_ack_i  (byte_ack),
    .byte_sel_i  (byte_sel),
    .byte_data_i (byte_data),
    .stop_i      (stop_det),
    .cmd_o       (cmd_o),
    .cmd_upd_o   (cmd_upd_o)
  );

  AST_NO_ACK_IN_RESET: assert property (@(posedge clk_i)
    !rst_ni |=> (!sda_oe_o || !rst_ni)); // R1
endmodule

// File: tb/i2c_cmd_reg_tb.sv
module i2c_cmd_reg_tb;
  localparam logic [6:0] ADDR = 7'h4B;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, upd;
  logic [15:0] cmd;
  wire sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  i2c_cmd_reg #(.DEV_ADDR(ADDR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cmd_o(cmd), .cmd_upd_o(upd)
  );

  int n_chk = 0, n_bad = 0, upd_seen = 0;
  bit done = 0, upd_prev = 0;

  // bench model
  logic [15:0] e_cmd = 16'hFF00, e_hold = 16'hFF00;
  bit e_pend = 0;
  int e_upd = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_addr_ack(input logic [6:0] a, input bit rw);
    return (a == ADDR) && !rw;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd) upd_seen++;
      if (upd && upd_prev) begin
        n_chk++; n_bad++;
        $display("FAIL R9: actual strobe width >1 expected 1");
      end
      upd_prev = upd;
    end
  end

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1; w(Q); m_scl = 1; w(Q); m_sda = 0; w(Q); m_scl = 0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 0; w(Q); m_scl = 1; w(Q); m_sda = 1; w(Q);
    if (e_pend) begin e_cmd = e_hold; e_pend = 0; e_upd++; end
    chk("R5/R6/R7 cmd after stop", cmd, e_cmd);
    chk("R9 strobe count", upd_seen, e_upd);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack);
    logic ack;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; w(Q); m_scl = 1; w(Q);
      if (i == 0) chk("R10 no drive before 8th fall", sda_oe, 0);
      w(Q); m_scl = 0; w(Q);
    end
    m_sda = 1; w(Q); m_scl = 1; w(Q);
    ack = sda_oe;
    chk("R2/R3/R4 ack", ack, exp_ack);
    w(Q); m_scl = 0; w(Q);
    chk("R10 release after 9th fall", sda_oe, 0);
    chk("R5 no early commit", cmd, e_cmd);
  endtask

  // one frame; leaves SCL low if no stop so the next start is a repeat start
  task automatic frame(input logic [6:0] a, input bit rw, input int nb,
                       input logic [31:0] data, input bit with_stop);
    bit hit;
    hit = exp_addr_ack(a, rw);
    bus_start();
    send_byte({a, rw}, hit);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b;
      b = data[31-8*i -: 8];
      send_byte(b, hit && i < 2);
      if (hit && i == 0) begin e_hold[15:8] = b; e_pend = 0; end
      if (hit && i == 1) begin e_hold[7:0] = b; e_pend = 1; end
    end
    if (with_stop) bus_stop();
  endtask

  initial begin
    void'($urandom(32'd2024));
    w(3);
    chk("R1 cmd reset", cmd, 16'hFF00);
    chk("R1 no ack drive", sda_oe, 0);
    chk("R1 no strobe", upd, 0);
    rst_n = 1; w(4);
    // R2 R4 R5 plain write
    frame(ADDR, 0, 2, 32'h1234_0000, 1);
    // R7 repeat starts to others, then stop
    frame(ADDR, 0, 2, 32'hABCD_0000, 0);
    frame(ADDR ^ 7'h11, 0, 2, 32'h5566_0000, 0);
    frame(ADDR ^ 7'h22, 0, 1, 32'h7700_0000, 0);
    frame(ADDR ^ 7'h01, 0, 0, 0, 1);
    // R6 stop mid frame
    frame(ADDR, 0, 1, 32'h9900_0000, 1);
    frame(ADDR, 0, 0, 0, 1);
    // R8 readdress after full pair, one byte, stop ignored
    frame(ADDR, 0, 2, 32'h5A5A_0000, 0);
    frame(ADDR, 0, 1, 32'h7700_0000, 1);
    chk("R8 cmd held", cmd, 16'hABCD);
    frame(ADDR, 0, 2, 32'h0F0F_0000, 1);
    // R3 read bit and wrong address, R4 third byte
    frame(ADDR, 1, 2, 32'h1111_0000, 1);
    frame(ADDR ^ 7'h40, 0, 2, 32'h2222_0000, 1);
    frame(ADDR, 0, 3, 32'hC3A5_E700, 1);
    chk("R4 byte order", cmd, 16'hC3A5);
    for (int k = 0; k < 90; k++) begin
      logic [6:0] a;
      bit rw;
      a = ($urandom % 10 < 7) ? ADDR : (ADDR ^ 7'(1 + $urandom % 127));
      rw = ($urandom % 10 == 0);
      frame(a, rw, $urandom % 4, $urandom, $urandom % 2);
    end
    bus_stop();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule